// File: doc/BRIEF.md
# ECC Single-Bit Error Logger

This block sits next to the SECDED decoder of a memory controller. Each time the decoder corrects a single-bit error on a read, it presents a one-cycle error pulse. The pulse comes with the check syndrome, the identifier of the agent that issued the read, and the address of the read. The logger copies these values into registers that software can read. It marks the entry as a single-bit event and sets an interrupt status flag. The core interrupt follows that flag.

The first error locks the log. The log keeps its contents, and later pulses are dropped, until software clears the status flag by writing a one to it. Clearing the flag also empties the log, so the next correctable error can be recorded. Software then rewrites the reported location with corrected data. A global enable input turns error capture and the interrupt output on or off.

Registers are read and written through a small word-addressed port. Reads are combinational. Writes take effect on the clock edge.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, all four registers (offsets 0x0, 0x4, 0x8, 0xC) read zero and `irq` is low.
- R2: An accepted error loads the log register at offset 0x0 on the next clock edge. The syndrome goes to bits [7:0] and the requester ID to bits [23:16]. Bit 8, the error-type flag, is 0, which marks a single-bit error. All other bits read zero.
- R3: An accepted error also loads the address registers. Offset 0x4 reads address bits [31:2] in bits [31:2], with bits [1:0] reading zero. Offset 0x8 reads address bits [ADDR_W-1:32], right-aligned, with the upper bits reading zero.
- R4: An error is accepted when `err_pulse` is high, `report_en` is high and the status flag is clear. On acceptance, status bit 0 at offset 0xC is set on the next edge. `irq` is high while that bit is set and `report_en` is high.
- R5: While status bit 0 is set, further error pulses change none of the three log registers.
- R6: A write to offset 0xC with data bit 0 equal to 1 clears the status bit and zeroes all three log registers on the next edge. A write to 0xC with bit 0 equal to 0 has no effect.
- R7: While `report_en` is low, error pulses are ignored and `irq` is held low. A status bit that is already set stays set.
- R8: When an error pulse and a clearing write to 0xC fall in the same cycle, the clear takes effect and that error is dropped. If the pulse is still presented in the following cycle, it is captured then.
- R9: Writes to offsets 0x0, 0x4 and 0x8 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; all state goes to zero |
| report_en | input | 1 | Global enable for error capture and the interrupt |
| err_pulse | input | 1 | One-cycle strobe marking a corrected single-bit error |
| err_syndrome | input | SYN_W | Syndrome of the corrected word |
| err_req_id | input | REQ_W | Identifier of the requester of the failing read |
| err_addr | input | ADDR_W | Address of the failing read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset; bits [3:2] select the word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Core interrupt |

## Verification
The assertions assume that the syndrome, requester ID and address are valid whenever `err_pulse` is high. They also assume that reset is released synchronously before any error or register traffic. The bench sets up every input field at the falling edge, before the pulse is sampled, and holds it steady through the capturing edge. It issues register writes only as single-cycle strobes. The assertions therefore never see a half-formed event. The same-cycle case in R8 is driven on purpose, by raising a pulse and a clearing write together.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned OFFSET_W   = 4;
  localparam int unsigned KIND_BIT   = 8;

  // Word index taken from offset bits [3:2]
  typedef enum logic [1:0] {
    SEL_LOG  = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_AHI  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [OFFSET_W-1:0] offset);
    return reg_sel_e'(offset[3:2]);
  endfunction

  // Log word: syndrome low byte, kind flag at bit 8, requester in third byte
  function automatic logic [REG_W-1:0] pack_log(input logic [FIELD_W-1:0] syn,
                                                input logic [FIELD_W-1:0] req,
                                                input logic               multi_bit);
    logic [REG_W-1:0] w;
    w         = '0;
    w[7:0]    = syn;
    w[KIND_BIT] = multi_bit;
    w[23:16]  = req;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] addr_low_word(input logic [63:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [REG_W-1:0] addr_high_word(input logic [63:0] a);
    return a[63:32];
  endfunction

endpackage

// File: rtl/ecclog_status.sv
module ecclog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic report_en,
  input  logic err_pulse,
  input  logic wr_stat,
  input  logic wr_bit0,
  output logic stat_q,
  output logic cap_ev,
  output logic clr_ev,
  output logic irq
);

  // Named events for the capture logic and the assertions
  assign clr_ev = wr_stat && wr_bit0;
  assign cap_ev = report_en && err_pulse && !stat_q && !clr_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (clr_ev) begin
      stat_q <= 1'b0;
    end else if (cap_ev) begin
      stat_q <= 1'b1;
    end
  end

  assign irq = report_en && stat_q;

  assert_stat_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> stat_q);

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !stat_q);

  assert_w0_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && wr_stat && !wr_bit0) |=> stat_q);

  assert_off_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!report_en && !stat_q) |=> !stat_q);

  assert_tie_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && report_en && wr_stat && wr_bit0) |=> !stat_q);

endmodule

// File: rtl/ecclog_capture.sv
module ecclog_capture
  import ecclog_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned REQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ev,
  input  logic              clr_ev,
  input  logic              locked,
  input  logic [SYN_W-1:0]  syn,
  input  logic [REQ_W-1:0]  req,
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  log_q,
  output logic [REG_W-1:0]  alo_q,
  output logic [REG_W-1:0]  ahi_q
);

  logic [63:0]      addr_ext;
  logic [REG_W-1:0] log_d;
  logic [REG_W-1:0] alo_d;
  logic [REG_W-1:0] ahi_d;

  assign addr_ext = 64'(addr);
  assign log_d    = pack_log(FIELD_W'(syn), FIELD_W'(req), 1'b0);
  assign alo_d    = addr_low_word(addr_ext);

  generate
    if (ADDR_W > 32) begin : g_wide_addr
      assign ahi_d = addr_high_word(addr_ext);
    end else begin : g_narrow_addr
      assign ahi_d = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
    end else if (clr_ev) begin
      log_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
    end else if (cap_ev) begin
      log_q <= log_d;
      alo_q <= alo_d;
      ahi_q <= ahi_d;
    end
  end

  assert_syn_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (log_q[7:0] == FIELD_W'($past(syn))) && !log_q[KIND_BIT]);

  assert_req_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> log_q[23:16] == FIELD_W'($past(req)));

  assert_addr_lsb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alo_q[1:0] == 2'b00);

  assert_log_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr_ev) |=> $stable(log_q) && $stable(alo_q) && $stable(ahi_q));

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> (log_q == '0) && (alo_q == '0) && (ahi_q == '0));

endmodule

// File: rtl/ecclog_regmux.sv
module ecclog_regmux
  import ecclog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OFFSET_W-1:0] rd_offset,
  input  logic [REG_W-1:0]    log_q,
  input  logic [REG_W-1:0]    alo_q,
  input  logic [REG_W-1:0]    ahi_q,
  input  logic                stat_q,
  output logic [REG_W-1:0]    rdata
);

  reg_sel_e rd_sel;
  assign rd_sel = decode_sel(rd_offset);

  always_comb begin
    unique case (rd_sel)
      SEL_LOG:  rdata = log_q;
      SEL_ALO:  rdata = alo_q;
      SEL_AHI:  rdata = ahi_q;
      SEL_STAT: rdata = {{(REG_W-1){1'b0}}, stat_q};
      default:  rdata = '0;
    endcase
  end

  assert_log_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_LOG) |-> (rdata[31:24] == 8'h00) && (rdata[15:9] == 7'h00));

  assert_stat_spare_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_STAT) |-> (rdata[31:1] == 31'h0));

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecclog_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned REQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              report_en,
  input  logic              err_pulse,
  input  logic [SYN_W-1:0]  err_syndrome,
  input  logic [REQ_W-1:0]  err_req_id,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  reg_sel_e         wr_sel;
  logic             wr_stat;
  logic             stat_q;
  logic             cap_ev;
  logic             clr_ev;
  logic [REG_W-1:0] log_q;
  logic [REG_W-1:0] alo_q;
  logic [REG_W-1:0] ahi_q;
  logic             unused_wdata;

  assign wr_sel       = decode_sel(reg_addr);
  assign wr_stat      = reg_wr && (wr_sel == SEL_STAT);
  assign unused_wdata = ^{reg_wdata[31:1], reg_addr[1:0]};

  ecclog_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .report_en (report_en),
    .err_pulse (err_pulse),
    .wr_stat   (wr_stat),
    .wr_bit0   (reg_wdata[0]),
    .stat_q    (stat_q),
    .cap_ev    (cap_ev),
    .clr_ev    (clr_ev),
    .irq       (irq)
  );

  ecclog_capture #(
    .ADDR_W (ADDR_W),
    .SYN_W  (SYN_W),
    .REQ_W  (REQ_W)
  ) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_ev (cap_ev),
    .clr_ev (clr_ev),
    .locked (stat_q),
    .syn    (err_syndrome),
    .req    (err_req_id),
    .addr   (err_addr),
    .log_q  (log_q),
    .alo_q  (alo_q),
    .ahi_q  (ahi_q)
  );

  ecclog_regmux u_regmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_offset (reg_addr),
    .log_q     (log_q),
    .alo_q     (alo_q),
    .ahi_q     (ahi_q),
    .stat_q    (stat_q),
    .rdata     (reg_rdata)
  );

  assert_ro_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (wr_sel != SEL_STAT) && !err_pulse) |=>
      $stable(log_q) && $stable(alo_q) && $stable(ahi_q) && $stable(stat_q));

endmodule

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb;

  localparam int ADDR_W = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              report_en;
  logic              err_pulse;
  logic [7:0]        err_syndrome;
  logic [7:0]        err_req_id;
  logic [ADDR_W-1:0] err_addr;
  logic              reg_wr;
  logic [3:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              irq;

  always #4 clk = ~clk;

  ecc_err_logger #(.ADDR_W(ADDR_W), .SYN_W(8), .REQ_W(8)) u_dut (
    .clk (clk), .rst_n (rst_n), .report_en (report_en), .err_pulse (err_pulse),
    .err_syndrome (err_syndrome), .err_req_id (err_req_id), .err_addr (err_addr),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .irq (irq)
  );

  typedef struct {
    logic [31:0] data;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic mon_req = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  // Expected-value model written from the requirements
  function automatic logic [31:0] exp_log(input logic [7:0] s, input logic [7:0] r);
    return {8'h00, r, 7'h00, 1'b0, s};
  endfunction
  function automatic logic [31:0] exp_lo(input logic [ADDR_W-1:0] a);
    return {a[31:2], 2'b00};
  endfunction
  function automatic logic [31:0] exp_hi(input logic [ADDR_W-1:0] a);
    return {24'h0, a[ADDR_W-1:32]};
  endfunction

  // Monitor: compares read data and irq at the falling edge
  always @(negedge clk) begin
    if (mon_req && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (reg_rdata !== e.data || irq !== e.irq) begin
        n_err++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, reg_rdata, irq, e.data, e.irq);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_rd(input logic [3:0] off, input logic [31:0] d,
                           input logic i, input string tag);
    exp_t e;
    e.data = d; e.irq = i; e.tag = tag;
    reg_addr = off;
    q.push_back(e);
    mon_req = 1'b1;
    step();
    mon_req = 1'b0;
  endtask

  task automatic set_err(input logic [7:0] s, input logic [7:0] r,
                         input logic [ADDR_W-1:0] a);
    err_syndrome = s; err_req_id = r; err_addr = a; err_pulse = 1'b1;
  endtask

  task automatic inject(input logic [7:0] s, input logic [7:0] r,
                        input logic [ADDR_W-1:0] a);
    set_err(s, r, a);
    step();
    err_pulse = 1'b0;
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic expect_all(input logic [31:0] l, input logic [31:0] lo,
                            input logic [31:0] hi, input logic st,
                            input logic i, input string tag);
    expect_rd(4'h0, l,  i, tag);
    expect_rd(4'h4, lo, i, tag);
    expect_rd(4'h8, hi, i, tag);
    expect_rd(4'hC, {31'h0, st}, i, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a1, a2, a3;
    a1 = 40'h12_3456_789B;
    a2 = 40'hAB_CDEF_0124;
    a3 = 40'hFF_FFFF_FFFF;
    rst_n = 1'b0; report_en = 1'b0; err_pulse = 1'b0;
    err_syndrome = '0; err_req_id = '0; err_addr = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    expect_all(32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R1 reset");

    // R2 R3 R4 first capture
    report_en = 1'b1;
    inject(8'h5A, 8'h13, a1);
    expect_all(exp_log(8'h5A, 8'h13), exp_lo(a1), exp_hi(a1), 1'b1, 1'b1, "R2 R3 R4 capture");

    // R5 lock while status set
    inject(8'hC3, 8'h77, a2);
    expect_all(exp_log(8'h5A, 8'h13), exp_lo(a1), exp_hi(a1), 1'b1, 1'b1, "R5 locked");

    // R6 writing 0 to status
    wr(4'hC, 32'hFFFF_FFFE);
    expect_rd(4'hC, 32'h1, 1'b1, "R6 write zero keeps");

    // R9 writes to read-only offsets
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    expect_all(exp_log(8'h5A, 8'h13), exp_lo(a1), exp_hi(a1), 1'b1, 1'b1, "R9 ro writes");

    // R6 write-1-to-clear
    wr(4'hC, 32'h0000_0001);
    expect_all(32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R6 clear");

    // R7 disabled reporting
    report_en = 1'b0;
    inject(8'h11, 8'h22, a2);
    expect_all(32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R7 ignored");
    report_en = 1'b1;
    inject(8'hC3, 8'h77, a2);
    report_en = 1'b0;
    expect_rd(4'hC, 32'h1, 1'b0, "R7 irq gated");
    report_en = 1'b1;
    expect_rd(4'h0, exp_log(8'hC3, 8'h77), 1'b1, "R7 irq restored");

    // R8 tie: clear and error together, error one cycle only
    set_err(8'h99, 8'h44, a3);
    wr(4'hC, 32'h1);
    err_pulse = 1'b0;
    expect_all(32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R8 clear wins");

    // R8 tie with error held into the next cycle
    inject(8'h01, 8'h02, a1);
    set_err(8'hFF, 8'h00, a3);
    wr(4'hC, 32'h1);
    step();
    err_pulse = 1'b0;
    expect_all(exp_log(8'hFF, 8'h00), exp_lo(a3), exp_hi(a3), 1'b1, 1'b1, "R8 held captured");

    // R2 R3 second pattern after clear
    wr(4'hC, 32'h1);
    inject(8'h80, 8'hFE, a2);
    expect_all(exp_log(8'h80, 8'hFE), exp_lo(a2), exp_hi(a2), 1'b1, 1'b1, "R2 R3 pattern two");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule